// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. On each clock it looks at the timer count, the count direction, an update-event pulse, a trigger pulse and a compare value. A 4-bit mode code then decides the next level of a registered reference output. The modes are:

- hold the current level;
- set, clear or invert the level on a count/compare match;
- force the level low or high;
- two edge-aligned pulse-width modes;
- two retriggerable single-pulse modes;
- two combined modes.

A second output, the combined reference, merges the channel's own reference with the reference of a neighbouring channel. In the combined modes it is an OR or an AND of the two. In every other mode it simply follows the channel's own reference.

The counter, the shadow registers, the output polarity and the dead-time logic all live elsewhere. The compare value, the mode and the neighbour's reference arrive here as plain inputs.

Top module: `oc_channel`

## Requirements
- R1: While `rst` is high at a clock edge, `ref_out` becomes 0. With mode 0 and `peer_ref` low, `comb_out` is then 0 as well.
- R2: Mode 0 (frozen) and the reserved codes 10, 11, 14 and 15 keep `ref_out` at its present level, whatever the count, compare, trigger and update inputs do.
- R3: Mode 1 sets `ref_out` to 1 on the edge after `cnt == cmp_val`. Mode 2 clears it to 0 on that edge. When there is no match, both modes hold the level.
- R4: Mode 3 inverts `ref_out` on the edge after each cycle where `cnt == cmp_val`, and holds it otherwise.
- R5: Mode 4 drives `ref_out` to 0 on the next edge and mode 5 drives it to 1, with no compare involved.
- R6: Mode 6 (pulse-width 1) gives `ref_out` the next-edge value below.
  - With `cnt_down` = 0: 1 when `cnt < cmp_val`, else 0.
  - With `cnt_down` = 1: 0 when `cnt > cmp_val`, else 1.
- R7: Mode 7 (pulse-width 2) gives the inverse of the mode 6 value for the same count, compare and direction.
- R8: Mode 8 keeps a single-pulse phase flag, and `ref_out` follows it.
  - Outside the phase, `ref_out` takes the idle level: 1 when counting up, 0 when counting down.
  - A `trig` pulse starts the phase. During the phase, `ref_out` follows the mode 6 value.
  - An `upd_evt` pulse ends the phase, and `ref_out` returns to the idle level on that same edge.
  - When `upd_evt` and `trig` come in the same cycle, the update wins.
- R9: Mode 9 uses the same phase flag as mode 8, with its levels complemented.
  - The idle level is 0 when counting up and 1 when counting down.
  - During the phase, `ref_out` follows the mode 7 value.
- R10: In mode 12, `ref_out` behaves as in mode 6 and `comb_out` = `ref_out` OR `peer_ref`. In mode 13, `ref_out` behaves as in mode 7 and `comb_out` = `ref_out` AND `peer_ref`. In both modes `comb_out` responds combinationally, within the same cycle.
- R11: In every mode other than 12 and 13, `comb_out` equals `ref_out`.
- R12: Only modes 8 and 9 keep the phase flag; any other mode clears it. A `trig` that arrives while the phase is already running changes nothing. The phase still ends at the next update event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CNT_W | Timer count value |
| cnt_down | input | 1 | 1 while the timer counts down |
| upd_evt | input | 1 | Update-event pulse |
| trig | input | 1 | Trigger pulse for the single-pulse modes |
| cmp_val | input | CNT_W | Compare value |
| mode | input | 4 | Output mode code |
| peer_ref | input | 1 | Reference of the neighbouring channel |
| ref_out | output | 1 | Registered reference level |
| comb_out | output | 1 | Combined reference |

## Verification
The assertions assume that `mode`, `cnt`, `cmp_val`, `cnt_down`, `trig` and `upd_evt` are stable and known at each rising edge. They also assume that one edge's decision depends only on the values present at that edge. Beyond that, they place no ordering constraint on trigger and update pulses, and the counter is not required to move monotonically.

The stimulus drives every input on the falling edge and holds it through the next rising edge. It uses a 4-bit configuration and sweeps:
- every mode code;
- both directions;
- every compare value;
- every count value.

Trigger and update pulses sit at fixed count positions. Some of these positions place a second trigger inside a running phase, and one places a trigger and an update in the same cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [3:0] {
    OCM_FROZEN  = 4'd0,
    OCM_SET     = 4'd1,
    OCM_CLR     = 4'd2,
    OCM_TOGGLE  = 4'd3,
    OCM_LOW     = 4'd4,
    OCM_HIGH    = 4'd5,
    OCM_PWM_A   = 4'd6,
    OCM_PWM_B   = 4'd7,
    OCM_PULSE_A = 4'd8,
    OCM_PULSE_B = 4'd9,
    OCM_RSV_10  = 4'd10,
    OCM_RSV_11  = 4'd11,
    OCM_MIX_OR  = 4'd12,
    OCM_MIX_AND = 4'd13,
    OCM_RSV_14  = 4'd14,
    OCM_RSV_15  = 4'd15
  } ocm_e;
endpackage

// File: rtl/oc_cmp.sv
module oc_cmp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_down,
  output logic             hit,
  output logic             pwm_a
);
  logic lt;
  logic gt;

  always_comb begin
    hit = (cnt == cmp_val);
    lt  = (cnt < cmp_val);
    gt  = (cnt > cmp_val);
    // Counting up: high below the compare value.
    // Counting down: low above it.
    pwm_a = cnt_down ? !gt : lt;
  end
endmodule

// File: rtl/oc_opm_phase.sv
module oc_opm_phase (
  input  logic clk,
  input  logic rst,
  input  logic opm_en,
  input  logic upd_evt,
  input  logic trig,
  output logic ph_next,
  output logic ph_q
);
  always_comb begin
    if (!opm_en)      ph_next = 1'b0;
    else if (upd_evt) ph_next = 1'b0;
    else if (trig)    ph_next = 1'b1;
    else              ph_next = ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b0;
    else     ph_q <= ph_next;
  end

  // R8
  upd_ends_phase_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> !ph_q);

  // R8
  trig_starts_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (opm_en && trig && !upd_evt) |=> ph_q);

  // R12
  phase_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    !opm_en |=> !ph_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             trig,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [3:0]       mode,
  input  logic             peer_ref,
  output logic             ref_out,
  output logic             comb_out
);
  import oc_pkg::*;

  ocm_e mode_e;
  logic hit;
  logic pwm_a;
  logic opm_en;
  logic ph_next;
  logic ph_q;
  logic ref_q;
  logic ref_d;

  assign mode_e = ocm_e'(mode);
  assign opm_en = (mode_e == OCM_PULSE_A) || (mode_e == OCM_PULSE_B);

  oc_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt      (cnt),
    .cmp_val  (cmp_val),
    .cnt_down (cnt_down),
    .hit      (hit),
    .pwm_a    (pwm_a)
  );

  oc_opm_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .opm_en  (opm_en),
    .upd_evt (upd_evt),
    .trig    (trig),
    .ph_next (ph_next),
    .ph_q    (ph_q)
  );

  always_comb begin
    ref_d = ref_q;
    unique case (mode_e)
      OCM_SET:     if (hit) ref_d = 1'b1;
      OCM_CLR:     if (hit) ref_d = 1'b0;
      OCM_TOGGLE:  if (hit) ref_d = !ref_q;
      OCM_LOW:     ref_d = 1'b0;
      OCM_HIGH:    ref_d = 1'b1;
      OCM_PWM_A,
      OCM_MIX_OR:  ref_d = pwm_a;
      OCM_PWM_B,
      OCM_MIX_AND: ref_d = !pwm_a;
      OCM_PULSE_A: ref_d = ph_next ? pwm_a  : !cnt_down;
      OCM_PULSE_B: ref_d = ph_next ? !pwm_a : cnt_down;
      default:     ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_d;
  end

  always_comb begin
    case (mode_e)
      OCM_MIX_OR:  comb_out = ref_q | peer_ref;
      OCM_MIX_AND: comb_out = ref_q & peer_ref;
      default:     comb_out = ref_q;
    endcase
  end

  assign ref_out = ref_q;

  // R2
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0 || mode == 4'd10 || mode == 4'd11 ||
     mode == 4'd14 || mode == 4'd15) |=> $stable(ref_out));

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd3 && cnt == cmp_val) |=> (ref_out != $past(ref_out)));

  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd4) |=> !ref_out);

  // R5
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd5) |=> ref_out);

  // R6
  pwm_up_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd6 && !cnt_down) |=> (ref_out == $past(cnt < cmp_val)));

  // R3
  set_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd1 && cnt == cmp_val) |=> ref_out);
endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] cnt;
  logic         cnt_down;
  logic         upd_evt;
  logic         trig;
  logic [W-1:0] cmp_val;
  logic [3:0]   mode;
  logic         peer_ref;
  logic         ref_out;
  logic         comb_out;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic exp_ref;
  logic exp_ph;

  always #5 clk = !clk;

  oc_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_down(cnt_down), .upd_evt(upd_evt),
    .trig(trig), .cmp_val(cmp_val), .mode(mode), .peer_ref(peer_ref),
    .ref_out(ref_out), .comb_out(comb_out)
  );

  function automatic string ref_tag(input logic [3:0] m);
    case (m)
      4'd1, 4'd2:   return "R3";
      4'd3:         return "R4";
      4'd4, 4'd5:   return "R5";
      4'd6, 4'd12:  return "R6";
      4'd7, 4'd13:  return "R7";
      4'd8:         return "R8/R12";
      4'd9:         return "R9/R12";
      default:      return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d cnt=%0d cmp=%0d dn=%0b: got %0b expected %0b",
               tag, mode, cnt, cmp_val, cnt_down, act, exp);
    end
  endtask

  // Reference model built from the requirements, one edge at a time.
  task automatic model_step();
    logic pw;
    logic hit;
    logic ph_n;
    hit = (cnt == cmp_val);
    pw  = cnt_down ? (cnt <= cmp_val) : (cnt < cmp_val);
    if (mode == 4'd8 || mode == 4'd9)
      ph_n = upd_evt ? 1'b0 : (trig ? 1'b1 : exp_ph);
    else
      ph_n = 1'b0;
    case (mode)
      4'd1:        if (hit) exp_ref = 1'b1;
      4'd2:        if (hit) exp_ref = 1'b0;
      4'd3:        if (hit) exp_ref = !exp_ref;
      4'd4:        exp_ref = 1'b0;
      4'd5:        exp_ref = 1'b1;
      4'd6, 4'd12: exp_ref = pw;
      4'd7, 4'd13: exp_ref = !pw;
      4'd8:        exp_ref = ph_n ? pw  : !cnt_down;
      4'd9:        exp_ref = ph_n ? !pw : cnt_down;
      default:     ;
    endcase
    exp_ph = ph_n;
  endtask

  initial begin
    rst = 1'b1; cnt = '0; cnt_down = 1'b0; upd_evt = 1'b0; trig = 1'b0;
    cmp_val = '0; mode = 4'd0; peer_ref = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", ref_out, 1'b0);
    check("R1", comb_out, 1'b0);
    exp_ref = 1'b0;
    exp_ph  = 1'b0;
    rst = 1'b0;
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < N; c++) begin
          for (int k = 0; k < N; k++) begin
            @(negedge clk);
            mode     = 4'(m);
            cnt_down = d[0];
            cmp_val  = W'(c);
            cnt      = d[0] ? W'(N - 1 - k) : W'(k);
            // Triggers at steps 3 and 6 (the second one retriggers),
            // update at step 10, both together at step 13.
            trig     = (k == 3) || (k == 6) || (k == 13);
            upd_evt  = (k == 10) || (k == 13);
            peer_ref = k[0] ^ c[1];
            @(posedge clk);
            model_step();
            #2;
            check(ref_tag(mode), ref_out, exp_ref);
            if (mode == 4'd12)
              check("R10", comb_out, exp_ref | peer_ref);
            else if (mode == 4'd13)
              check("R10", comb_out, exp_ref & peer_ref);
            else
              check("R11", comb_out, exp_ref);
          end
        end
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule